// File: doc/BRIEF.md
# Card Bus Power-State Controller

This block owns the power state of a removable-card bus. A host register interface writes a small control word. Its two low bits select the bus power state. The block turns that state into the drive mode of the card clock, command and data pins, an enable for the bus clock, and a flag that keeps the rest of the card controller idle.

The state encoding is fixed by the register:

| Value | State |
|-------|-------|
| 00 | power-off |
| 10 | power-cycle |
| 11 | power-on |
| 01 | reserved |

- **Power-cycle** pulls every card line low, so the card cannot draw current through its signal pins.
- **Power-off** parks the lines high while the controller stays disabled.
- **Power-on** starts the bus clock. The controller is held disabled for a fixed number of card clock periods, counted on a one-cycle tick that a clock divider elsewhere supplies. When that count finishes, the block releases the controller and gives a single-cycle ready pulse to the command and data paths.

Bit 4 of the control word is a pad-direction polarity bit and is passed to the pads. Bits 2 and 3 belong to voltage-switch logic outside this block and have no effect here. Out of reset the field reads power-off, but the pins float (high impedance) until the first accepted write.

Top module: `cardpwr_ctrl`

## Requirements
- R1: After reset the block reports field 00, line mode HIZ (code 0), bus clock enable 0, controller disabled 1, ready 0 and pad direction polarity 0.
- R2: An accepted write whose bits [1:0] are 00 (power-off) sets line mode HIGH (code 2), bus clock enable 0 and controller disabled 1. This also applies to the first write after reset, when the field already reads 00.
- R3: An accepted write whose bits [1:0] are 10 (power-cycle) sets line mode LOW (code 1), bus clock enable 0 and controller disabled 1.
- R4: An accepted write of 11 (power-on) sets line mode ACTIVE (code 3) and bus clock enable 1. The controller stays disabled until WARMUP_CYCLES (default 74) card clock ticks have been seen in power-on. It is enabled in the cycle after the edge that takes the last tick.
- R5: `ctrl_ready` is high for exactly one clock cycle, in the first cycle in which the controller is enabled.
- R6: A write whose bits [1:0] are 01 is ignored as a whole: field, line mode and direction polarity keep their values.
- R7: Leaving power-on and later entering it again restarts the warm-up count from zero.
- R8: Bit 4 of an accepted write appears on `pad_dir_pol` from the next cycle. Bits 2 and 3 have no effect on any output.
- R9: Card clock ticks outside power-on are not counted. A repeated write of 11 while already in power-on does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control-word write strobe |
| cfg_wdata | input | 5 | Control word: [1:0] power field, [3:2] voltage bits (unused), [4] direction polarity |
| card_clk_tick | input | 1 | One-cycle pulse per card clock period |
| pwr_field | output | 2 | Current power field |
| line_mode | output | 2 | Pin drive mode: 0 HIZ, 1 LOW, 2 HIGH, 3 ACTIVE |
| bus_clk_en | output | 1 | Card bus clock enable |
| ctrl_disabled | output | 1 | Command and data controller held off |
| ctrl_ready | output | 1 | One-cycle pulse when the controller becomes enabled |
| pad_dir_pol | output | 1 | Pad direction polarity |

## Verification
The bench writes power-off first, while the field already reads 00. A design that keyed the pin mode on the field alone would leave the lines floating instead of driving them high.

It steps the tick count to one short of the warm-up length and then to exactly that length. An off-by-one counter would release the controller a tick early or late.

It gives ticks during power-cycle and repeats a power-on write in the middle of warm-up. A design that counted stray ticks, or restarted on the repeat write, would enable at the wrong moment.

It writes the reserved code and leaves and re-enters power-on. A design that accepted 01, or kept a stale count, would show the wrong pin mode or skip warm-up.

// File: rtl/cardpwr_pkg.sv
package cardpwr_pkg;

    localparam int CFG_W     = 5;
    localparam int FIELD_LSB = 0;
    localparam int FIELD_W   = 2;
    localparam int DIR_BIT   = 4;

    typedef enum logic [1:0] {
        PWR_OFF   = 2'b00,
        PWR_RSVD  = 2'b01,
        PWR_CYCLE = 2'b10,
        PWR_ON    = 2'b11
    } pwr_field_e;

    typedef enum logic [1:0] {
        LINE_HIZ    = 2'd0,
        LINE_LOW    = 2'd1,
        LINE_HIGH   = 2'd2,
        LINE_ACTIVE = 2'd3
    } line_mode_e;

    // fresh: no write accepted since reset, pins still floating
    typedef struct packed {
        logic       fresh;
        logic       dir_pol;
        pwr_field_e field;
    } pwr_reg_t;

    function automatic logic is_reserved(input logic [FIELD_W-1:0] f);
        return f == PWR_RSVD;
    endfunction

    function automatic line_mode_e mode_of(input pwr_reg_t r);
        line_mode_e m;
        if (r.fresh) begin
            m = LINE_HIZ;
        end else begin
            case (r.field)
                PWR_CYCLE: m = LINE_LOW;
                PWR_ON:    m = LINE_ACTIVE;
                default:   m = LINE_HIGH;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/cardpwr_field_reg.sv
module cardpwr_field_reg
    import cardpwr_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output pwr_reg_t      cur
);
    logic [FIELD_W-1:0] new_field;
    logic               accept;
    logic               unused_vsw;

    assign new_field  = wdata[FIELD_LSB +: FIELD_W];
    assign accept     = wr_en && !is_reserved(new_field);
    assign unused_vsw = ^wdata[3:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{fresh: 1'b1, dir_pol: 1'b0, field: PWR_OFF};
        end else if (accept) begin
            cur <= '{fresh: 1'b0, dir_pol: wdata[DIR_BIT], field: pwr_field_e'(new_field)};
        end
    end
endmodule

// File: rtl/cardpwr_warmup.sv
module cardpwr_warmup #(
    parameter int WARMUP_CYCLES = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done,
    output logic ready_pulse
);
    localparam int CW = $clog2(WARMUP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WARMUP_CYCLES);

    logic [CW-1:0] cnt;
    logic          done_d;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done_d <= 1'b0;
        else     done_d <= done;
    end

    assign done        = run && (cnt == LAST);
    assign ready_pulse = done && !done_d;
endmodule

// File: rtl/cardpwr_pad_decode.sv
module cardpwr_pad_decode
    import cardpwr_pkg::*;
(
    input  pwr_reg_t    cur,
    input  logic        warm_done,
    output line_mode_e  mode,
    output logic        clk_en,
    output logic        disabled,
    output logic        dir_pol
);
    always_comb begin
        mode     = mode_of(cur);
        clk_en   = !cur.fresh && (cur.field == PWR_ON);
        disabled = !(clk_en && warm_done);
        dir_pol  = cur.dir_pol;
    end
endmodule

// File: rtl/cardpwr_ctrl.sv
module cardpwr_ctrl
    import cardpwr_pkg::*;
#(
    parameter int WARMUP_CYCLES = 74
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             card_clk_tick,
    output logic [1:0]       pwr_field,
    output logic [1:0]       line_mode,
    output logic             bus_clk_en,
    output logic             ctrl_disabled,
    output logic             ctrl_ready,
    output logic             pad_dir_pol
);
    pwr_reg_t   cur;
    line_mode_e mode;
    logic       in_on;
    logic       warm_done;

    cardpwr_field_reg #(.W(CFG_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cur   (cur)
    );

    assign in_on = !cur.fresh && (cur.field == PWR_ON);

    cardpwr_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
        .clk         (clk),
        .rst         (rst),
        .run         (in_on),
        .tick        (card_clk_tick),
        .done        (warm_done),
        .ready_pulse (ctrl_ready)
    );

    cardpwr_pad_decode u_dec (
        .cur       (cur),
        .warm_done (warm_done),
        .mode      (mode),
        .clk_en    (bus_clk_en),
        .disabled  (ctrl_disabled),
        .dir_pol   (pad_dir_pol)
    );

    assign pwr_field = cur.field;
    assign line_mode = mode;
endmodule

// File: rtl/cardpwr_ctrl_chk.sv
module cardpwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr_en,
    input logic [4:0] cfg_wdata,
    input logic [1:0] pwr_field,
    input logic [1:0] line_mode,
    input logic       bus_clk_en,
    input logic       ctrl_disabled,
    input logic       ctrl_ready
);
    // R3: power-cycle drives lines low with the clock stopped
    a_r3_cycle_low: assert property (@(posedge clk) disable iff (rst)
        (pwr_field == 2'b10) |-> (line_mode == 2'd1 && !bus_clk_en));

    // R4: an enabled controller always has a running clock and active lines
    a_r4_enabled_means_on: assert property (@(posedge clk) disable iff (rst)
        !ctrl_disabled |-> (bus_clk_en && line_mode == 2'd3));

    // R5: ready only on the first enabled cycle
    a_r5_ready_edge: assert property (@(posedge clk) disable iff (rst)
        ctrl_ready |-> (!ctrl_disabled && $past(ctrl_disabled)));

    // R6: the reserved code never changes the field
    a_r6_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wdata[1:0] == 2'b01) |=> $stable(pwr_field));

    // R7: each entry into power-on begins with the controller disabled
    a_r7_entry_disabled: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_clk_en) |-> ctrl_disabled);

    // R9: outside power-on the controller is never enabled
    a_r9_off_disabled: assert property (@(posedge clk) disable iff (rst)
        (pwr_field != 2'b11) |-> ctrl_disabled);
endmodule

bind cardpwr_ctrl cardpwr_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wdata     (cfg_wdata),
    .pwr_field     (pwr_field),
    .line_mode     (line_mode),
    .bus_clk_en    (bus_clk_en),
    .ctrl_disabled (ctrl_disabled),
    .ctrl_ready    (ctrl_ready)
);

// File: tb/cardpwr_ctrl_test.sv
`timescale 1ns/1ps
module cardpwr_ctrl_test;
    localparam int WARM = 74;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       card_clk_tick = 1'b0;
    logic [1:0] pwr_field;
    logic [1:0] line_mode;
    logic       bus_clk_en;
    logic       ctrl_disabled;
    logic       ctrl_ready;
    logic       pad_dir_pol;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cardpwr_ctrl #(.WARMUP_CYCLES(WARM)) uut (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wdata     (cfg_wdata),
        .card_clk_tick (card_clk_tick),
        .pwr_field     (pwr_field),
        .line_mode     (line_mode),
        .bus_clk_en    (bus_clk_en),
        .ctrl_disabled (ctrl_disabled),
        .ctrl_ready    (ctrl_ready),
        .pad_dir_pol   (pad_dir_pol)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            card_clk_tick = 1'b1;
            @(negedge clk);
            card_clk_tick = 1'b0;
            #1;
        end
    endtask

    task automatic t_reset;
        check("R1 field", pwr_field, 0);
        check("R1 mode", line_mode, 0);
        check("R1 clk_en", bus_clk_en, 0);
        check("R1 disabled", ctrl_disabled, 1);
        check("R1 ready", ctrl_ready, 0);
        check("R1 dir", pad_dir_pol, 0);
    endtask

    task automatic t_power_off;
        wr(5'b00000);
        check("R2 mode high", line_mode, 2);
        check("R2 clk_en", bus_clk_en, 0);
        check("R2 disabled", ctrl_disabled, 1);
    endtask

    task automatic t_power_cycle;
        wr(5'b00010);
        check("R3 field", pwr_field, 2);
        check("R3 mode low", line_mode, 1);
        check("R3 clk_en", bus_clk_en, 0);
        check("R3 disabled", ctrl_disabled, 1);
    endtask

    task automatic t_reserved;
        wr(5'b10001);
        check("R6 field kept", pwr_field, 2);
        check("R6 mode kept", line_mode, 1);
        check("R6 dir kept", pad_dir_pol, 0);
    endtask

    task automatic t_warmup;
        ticks(10); // R9: ticks in power-cycle must not count
        wr(5'b10011);
        check("R8 dir set", pad_dir_pol, 1);
        check("R4 mode active", line_mode, 3);
        check("R4 clk_en", bus_clk_en, 1);
        check("R4 disabled at entry", ctrl_disabled, 1);
        ticks(WARM - 1);
        check("R4 disabled one short", ctrl_disabled, 1);
        check("R9 no early enable", ctrl_ready, 0);
        wr(5'b10011); // R9: repeat write must not restart
        check("R9 still disabled", ctrl_disabled, 1);
        ticks(1);
        check("R4 enabled", ctrl_disabled, 0);
        check("R5 ready pulse", ctrl_ready, 1);
        @(negedge clk); #1;
        check("R5 ready one cycle", ctrl_ready, 0);
        check("R5 stays enabled", ctrl_disabled, 0);
    endtask

    task automatic t_dir_vsw;
        wr(5'b11111);
        check("R8 vsw no effect field", pwr_field, 3);
        check("R8 vsw no effect enable", ctrl_disabled, 0);
        check("R8 dir held", pad_dir_pol, 1);
        wr(5'b01111);
        check("R8 dir cleared", pad_dir_pol, 0);
        check("R8 mode", line_mode, 3);
    endtask

    task automatic t_restart;
        wr(5'b00010);
        check("R7 cycle disables", ctrl_disabled, 1);
        check("R7 cycle mode", line_mode, 1);
        wr(5'b00011);
        check("R7 reentry disabled", ctrl_disabled, 1);
        ticks(WARM - 1);
        check("R7 count restarted", ctrl_disabled, 1);
        ticks(1);
        check("R7 enabled again", ctrl_disabled, 0);
        check("R7 ready again", ctrl_ready, 1);
        wr(5'b00000);
        check("R2 off from on mode", line_mode, 2);
        check("R2 off from on disabled", ctrl_disabled, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_power_off();
        t_power_cycle();
        t_reserved();
        t_warmup();
        t_dir_vsw();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule